// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block translates effective addresses into physical addresses for a RISC core, using a small set-associative cache of page translations. Pages are 4096 bytes. The low 12 address bits pass through unchanged. The upper 20 bits form the virtual page number (VPN), and its low bits pick the set. By default there are 16 sets of 2 ways. Each way of each set owns two words, a match word and a translate word. Software refills entries only by writing these words through a configuration port, addressed by register kind, way and set. The block never walks page tables.

Lookups arrive on a valid/ready stream carrying the effective address, an access code and a privilege bit. Results leave one cycle after acceptance on a second valid/ready stream. A result shows the physical address and exactly one of hit, miss or protection fault, plus a cache-inhibit flag. While `res_valid` is high and `res_ready` is low, the result is held unchanged and `lk_ready` is low, so no new lookup is taken. A lookup is accepted in any cycle where `lk_valid` and `lk_ready` are both high.

On a miss or a fault, the full effective address is latched into `fault_ea`. Software then reads the per-way recently-used bits to choose a refill victim: the first way whose bit reads zero.

Top module: `tlb_assoc`

## Requirements
- R1: After reset, `res_valid` is 0, `lk_ready` is 1, `fault_ea` is 0, and every match and translate word reads 0.
- R2: A configuration write with `cfg_kind`=1 stores the whole translate word, which reads back unchanged. A write with `cfg_kind`=0 stores the match word, which reads back as VPN in bits 31:12, recently-used in bit 1 and valid in bit 0, with bits 11:2 reading zero. Writing zero invalidates the entry.
- R3: A lookup accepted with translation enabled that finds a valid way in its set whose VPN equals `ea[31:12]`, and whose permission allows the access, returns on the next cycle `res_hit`=1, `res_pa` = {translate bits 31:12, `ea[11:0]`}, and `res_ci` = translate bit 1.
- R4: A lookup with no valid matching way in its set returns `res_miss`=1 with `res_pa` = ea. `fault_ea` takes the full effective address on the same edge. `fault_ea` changes only on a miss or a fault.
- R5: Clearing only the valid bit of a match word, while keeping its VPN, makes the next lookup of that page miss.
- R6: The set searched is `ea[15:12]` (VPN modulo the set count). An entry placed in a different set never hits, even when its VPN matches.
- R7: On a hit, the hit way's recently-used bit becomes 1 and every other way's bit in that set becomes 0. Misses and faults leave these bits unchanged.
- R8: Permission bits in the translate word are: user read, bit 6; user write, bit 7; supervisor read, bit 8; supervisor write, bit 9. `lk_acc` codes are 0 load, 1 store, 2 fetch; fetch and load both need the read enable. `lk_sup`=1 selects the supervisor bits. A matching but disallowed access returns `res_fault`=1, not a hit, and latches `fault_ea`.
- R9: With `xlate_en`=0, `res_pa` equals the effective address, hit, miss, fault and `res_ci` are all 0, and `fault_ea` is unchanged.
- R10: `lk_ready` = !`res_valid` | `res_ready`. While a result is stalled, it stays stable.
- R11: Two ways of the same set can hold different pages at the same time, and each of them hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | Translation enable |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high with valid |
| lk_ea | input | 32 | Effective address |
| lk_acc | input | 2 | Access code: 0 load, 1 store, 2 fetch |
| lk_sup | input | 1 | Supervisor privilege |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_pa | output | 32 | Physical address |
| res_hit | output | 1 | Translation hit |
| res_miss | output | 1 | No valid matching way |
| res_fault | output | 1 | Permission violation |
| res_ci | output | 1 | Cache inhibit for the hit page |
| fault_ea | output | 32 | Address of the last miss or fault |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 match word, 1 translate word |
| cfg_way | input | WAY_W | Way selector |
| cfg_set | input | SET_W | Set selector |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed word (combinational) |

## Verification
The assertions assume the consumer obeys the stream rules. A lookup counts only on a cycle where valid and ready are both high, and `xlate_en` is sampled on that same cycle. The bench drives every input half a cycle away from the clock edge. It holds `lk_valid` until it sees `lk_ready`, so no request is dropped or doubled. It toggles `xlate_en` only between lookups, and it makes configuration writes only while no lookup to the same set is in flight. The outcome therefore never depends on a write and a recently-used update colliding in the same cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ADDR_W    = 32;
  localparam int PAGE_BITS = 12;
  localparam int PN_W      = ADDR_W - PAGE_BITS;

  // match word field positions
  localparam int MW_VALID = 0;
  localparam int MW_RECENT = 1;

  // translate word field positions
  localparam int TW_CI  = 1;
  localparam int TW_URE = 6;
  localparam int TW_UWE = 7;
  localparam int TW_SRE = 8;
  localparam int TW_SWE = 9;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef struct packed {
    logic [PN_W-1:0] ppn;
    logic            ci;
    logic            ure;
    logic            uwe;
    logic            sre;
    logic            swe;
  } tr_fields_t;

  function automatic tr_fields_t unpack_tr(input logic [ADDR_W-1:0] w);
    tr_fields_t f;
    f.ppn = w[ADDR_W-1:PAGE_BITS];
    f.ci  = w[TW_CI];
    f.ure = w[TW_URE];
    f.uwe = w[TW_UWE];
    f.sre = w[TW_SRE];
    f.swe = w[TW_SWE];
    return f;
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 2,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic                       cfg_kind,
  input  logic [WAY_W-1:0]           cfg_way,
  input  logic [SET_W-1:0]           cfg_set,
  input  logic [ADDR_W-1:0]          cfg_wdata,
  output logic [ADDR_W-1:0]          cfg_rdata,
  input  logic [SET_W-1:0]           lk_set,
  output logic [WAYS-1:0][PN_W-1:0]  way_vpn,
  output logic [WAYS-1:0]            way_valid,
  output tr_fields_t [WAYS-1:0]      way_tr,
  input  logic                       touch_en,
  input  logic [WAYS-1:0]            touch_oh
);
  logic [PN_W-1:0]   vpn_q    [SETS][WAYS];
  logic              valid_q  [SETS][WAYS];
  logic              recent_q [SETS][WAYS];
  logic [ADDR_W-1:0] tr_q     [SETS][WAYS];

  logic way_ok;
  assign way_ok = {{(32-WAY_W){1'b0}}, cfg_way} < 32'(WAYS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          vpn_q[s][w]    <= '0;
          valid_q[s][w]  <= 1'b0;
          recent_q[s][w] <= 1'b0;
          tr_q[s][w]     <= '0;
        end
      end
    end else begin
      if (touch_en) begin
        for (int w = 0; w < WAYS; w++) recent_q[lk_set][w] <= touch_oh[w];
      end
      if (cfg_we && way_ok) begin
        if (cfg_kind) begin
          tr_q[cfg_set][cfg_way] <= cfg_wdata;
        end else begin
          vpn_q[cfg_set][cfg_way]    <= cfg_wdata[ADDR_W-1:PAGE_BITS];
          valid_q[cfg_set][cfg_way]  <= cfg_wdata[MW_VALID];
          recent_q[cfg_set][cfg_way] <= cfg_wdata[MW_RECENT];
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (way_ok) begin
      if (cfg_kind) begin
        cfg_rdata = tr_q[cfg_set][cfg_way];
      end else begin
        cfg_rdata[ADDR_W-1:PAGE_BITS] = vpn_q[cfg_set][cfg_way];
        cfg_rdata[MW_RECENT]          = recent_q[cfg_set][cfg_way];
        cfg_rdata[MW_VALID]           = valid_q[cfg_set][cfg_way];
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign way_vpn[w]   = vpn_q[lk_set][w];
    assign way_valid[w] = valid_q[lk_set][w];
    assign way_tr[w]    = unpack_tr(tr_q[lk_set][w]);
  end
endmodule

// File: rtl/tlb_way_cmp.sv
module tlb_way_cmp
  import tlb_pkg::*;
(
  input  logic [PN_W-1:0] entry_vpn,
  input  logic            entry_valid,
  input  logic [PN_W-1:0] req_vpn,
  output logic            match
);
  assign match = entry_valid && (entry_vpn == req_vpn);
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import tlb_pkg::*;
#(
  parameter int WAYS = 2
) (
  input  logic [WAYS-1:0]       way_hit,
  input  tr_fields_t [WAYS-1:0] way_tr,
  input  logic [ADDR_W-1:0]     ea,
  input  logic [1:0]            acc,
  input  logic                  sup,
  input  logic                  xlate_en,
  output logic [ADDR_W-1:0]     pa,
  output logic                  hit,
  output logic                  miss,
  output logic                  fault,
  output logic                  ci,
  output logic [WAYS-1:0]       hit_oh
);
  tr_fields_t      sel;
  logic            found;
  logic [WAYS-1:0] first_oh;
  logic            is_store;
  logic            allowed;

  // lowest-numbered matching way wins
  always_comb begin
    sel      = '0;
    found    = 1'b0;
    first_oh = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w] && !found) begin
        found       = 1'b1;
        sel         = way_tr[w];
        first_oh[w] = 1'b1;
      end
    end
  end

  assign is_store = (acc_e'(acc) == ACC_STORE);
  assign allowed  = sup ? (is_store ? sel.swe : sel.sre)
                        : (is_store ? sel.uwe : sel.ure);

  always_comb begin
    pa    = ea;
    hit   = 1'b0;
    miss  = 1'b0;
    fault = 1'b0;
    ci    = 1'b0;
    if (xlate_en) begin
      if (!found) begin
        miss = 1'b1;
      end else if (!allowed) begin
        fault = 1'b1;
      end else begin
        hit = 1'b1;
        ci  = sel.ci;
        pa  = {sel.ppn, ea[PAGE_BITS-1:0]};
      end
    end
  end

  assign hit_oh = hit ? first_oh : '0;
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 2,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlate_en,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_ea,
  input  logic [1:0]        lk_acc,
  input  logic              lk_sup,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_pa,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_fault,
  output logic              res_ci,
  output logic [ADDR_W-1:0] fault_ea,
  input  logic              cfg_we,
  input  logic              cfg_kind,
  input  logic [WAY_W-1:0]  cfg_way,
  input  logic [SET_W-1:0]  cfg_set,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata
);
  logic [WAYS-1:0][PN_W-1:0] way_vpn;
  logic [WAYS-1:0]           way_valid;
  tr_fields_t [WAYS-1:0]     way_tr;
  logic [WAYS-1:0]           way_hit;
  logic [WAYS-1:0]           hit_oh;
  logic [SET_W-1:0]          lk_set;
  logic [ADDR_W-1:0]         nx_pa;
  logic                      nx_hit, nx_miss, nx_fault, nx_ci;
  logic                      accept;

  assign lk_set   = lk_ea[PAGE_BITS +: SET_W];
  assign lk_ready = !res_valid || res_ready;
  assign accept   = lk_valid && lk_ready;

  tlb_entry_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_way(cfg_way),
    .cfg_set(cfg_set), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lk_set(lk_set), .way_vpn(way_vpn), .way_valid(way_valid),
    .way_tr(way_tr), .touch_en(accept && nx_hit), .touch_oh(hit_oh)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    tlb_way_cmp u_cmp (
      .entry_vpn(way_vpn[w]), .entry_valid(way_valid[w]),
      .req_vpn(lk_ea[ADDR_W-1:PAGE_BITS]), .match(way_hit[w])
    );
  end

  tlb_resolve #(.WAYS(WAYS)) u_resolve (
    .way_hit(way_hit), .way_tr(way_tr), .ea(lk_ea), .acc(lk_acc),
    .sup(lk_sup), .xlate_en(xlate_en), .pa(nx_pa), .hit(nx_hit),
    .miss(nx_miss), .fault(nx_fault), .ci(nx_ci), .hit_oh(hit_oh)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_pa    <= '0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_fault <= 1'b0;
      res_ci    <= 1'b0;
      fault_ea  <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_pa    <= nx_pa;
      res_hit   <= nx_hit;
      res_miss  <= nx_miss;
      res_fault <= nx_fault;
      res_ci    <= nx_ci;
      if (nx_miss || nx_fault) fault_ea <= lk_ea;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xlate_en,
  input logic        lk_valid,
  input logic        lk_ready,
  input logic [31:0] lk_ea,
  input logic        res_valid,
  input logic        res_ready,
  input logic [31:0] res_pa,
  input logic        res_hit,
  input logic        res_miss,
  input logic        res_fault,
  input logic [31:0] fault_ea
);
  logic acc;
  assign acc = lk_valid && lk_ready;

  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> lk_ready); // R10
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_pa) && $stable(res_hit)
      && $stable(res_miss) && $stable(res_fault))); // R10
  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones({res_hit, res_miss, res_fault}) <= 1)); // R3
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (res_pa[11:0] == $past(lk_ea[11:0]))); // R3
  AST_FAULT_EA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (!(res_miss || res_fault) || fault_ea == $past(lk_ea))); // R4
  AST_FAULT_EA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(fault_ea)); // R4
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !xlate_en) |=> (res_pa == $past(lk_ea) && !res_hit && !res_miss
      && !res_fault)); // R9
endmodule

bind tlb_assoc tlb_assoc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .lk_valid(lk_valid),
  .lk_ready(lk_ready), .lk_ea(lk_ea), .res_valid(res_valid),
  .res_ready(res_ready), .res_pa(res_pa), .res_hit(res_hit),
  .res_miss(res_miss), .res_fault(res_fault), .fault_ea(fault_ea)
);

// File: tb/tlb_assoc_bench.sv
module tlb_assoc_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlate_en = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_ea = '0;
  logic [1:0]  lk_acc = '0;
  logic        lk_sup = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_pa;
  logic        res_hit, res_miss, res_fault, res_ci;
  logic [31:0] fault_ea;
  logic        cfg_we = 1'b0;
  logic        cfg_kind = 1'b0;
  logic [0:0]  cfg_way = '0;
  logic [3:0]  cfg_set = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  int n_tests = 0;
  int n_fail = 0;

  typedef struct {
    logic [31:0] pa;
    logic hit, miss, fault, ci;
    logic [31:0] ea;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_assoc u_tlb_assoc (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_ea(lk_ea), .lk_acc(lk_acc), .lk_sup(lk_sup),
    .res_valid(res_valid), .res_ready(res_ready), .res_pa(res_pa),
    .res_hit(res_hit), .res_miss(res_miss), .res_fault(res_fault),
    .res_ci(res_ci), .fault_ea(fault_ea), .cfg_we(cfg_we),
    .cfg_kind(cfg_kind), .cfg_way(cfg_way), .cfg_set(cfg_set),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
    end
  endtask

  task automatic cfg_write(input bit kind, input int way, input int set,
                           input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = kind; cfg_way = way[0:0];
    cfg_set = set[3:0]; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input bit kind, input int way, input int set,
                          output logic [31:0] data);
    @(negedge clk);
    cfg_kind = kind; cfg_way = way[0:0]; cfg_set = set[3:0];
    #(CLK_PERIOD/4);
    data = cfg_rdata;
  endtask

  // driver: pushes the expected result, then holds the request until taken
  task automatic lookup(input logic [31:0] ea, input logic [1:0] acc,
                        input bit sup, input exp_t e);
    bit taken;
    e.ea = ea;
    @(negedge clk);
    exp_q.push_back(e);
    lk_valid = 1'b1; lk_ea = ea; lk_acc = acc; lk_sup = sup;
    do begin
      #(CLK_PERIOD/4);
      taken = lk_ready;
      @(negedge clk);
    end while (!taken);
    lk_valid = 1'b0;
  endtask

  function automatic exp_t mk(input logic [31:0] pa, input bit h, input bit m,
                              input bit f, input bit c, input string req);
    exp_t e;
    e.pa = pa; e.hit = h; e.miss = m; e.fault = f; e.ci = c;
    e.ea = '0; e.req = req;
    return e;
  endfunction

  // monitor: compares each result in the cycle it is handed over
  initial begin
    forever begin
      @(negedge clk);
      #(3*CLK_PERIOD/4 - CLK_PERIOD/2);
      if (rst_n && res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected result", res_pa, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(res_pa == e.pa, {e.req, " pa"}, res_pa, e.pa);
          check({res_hit, res_miss, res_fault} == {e.hit, e.miss, e.fault},
                {e.req, " outcome"}, {29'd0, res_hit, res_miss, res_fault},
                {29'd0, e.hit, e.miss, e.fault});
          check(res_ci == e.ci, {e.req, " ci"}, {31'd0, res_ci}, {31'd0, e.ci});
          if (e.miss || e.fault)
            check(fault_ea == e.ea, {e.req, " fault_ea"}, fault_ea, e.ea);
        end
      end
    end
  end

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] ea_keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #(CLK_PERIOD/4);
    check(res_valid == 1'b0, "R1 res_valid", {31'd0, res_valid}, 32'h0);
    check(lk_ready == 1'b1, "R1 lk_ready", {31'd0, lk_ready}, 32'h1);
    check(fault_ea == 32'h0, "R1 fault_ea", fault_ea, 32'h0);
    cfg_read(1'b0, 0, 5, rd);
    check(rd == 32'h0, "R1 match word", rd, 32'h0);
    cfg_read(1'b1, 1, 15, rd);
    check(rd == 32'h0, "R1 translate word", rd, 32'h0);

    // R2 register access: bits 11:2 of a match word drop
    cfg_write(1'b0, 0, 5, 32'h4000_5FFD);
    cfg_read(1'b0, 0, 5, rd);
    check(rd == 32'h4000_5001, "R2 match readback", rd, 32'h4000_5001);
    cfg_write(1'b1, 0, 5, 32'h8012_3142);
    cfg_read(1'b1, 0, 5, rd);
    check(rd == 32'h8012_3142, "R2 translate readback", rd, 32'h8012_3142);
    cfg_write(1'b0, 1, 5, 32'h1234_5001);
    cfg_write(1'b1, 1, 5, 32'h0077_73C0);

    xlate_en = 1'b1;
    // R3 hit with cache inhibit
    lookup(32'h4000_5ABC, 2'd0, 1'b0, mk(32'h8012_3ABC, 1, 0, 0, 1, "R3 hit"));
    // R7 recently-used after way 0 hit
    cfg_read(1'b0, 0, 5, rd);
    check(rd == 32'h4000_5003, "R7 way0 marked", rd, 32'h4000_5003);
    cfg_read(1'b0, 1, 5, rd);
    check(rd == 32'h1234_5001, "R7 way1 cleared", rd, 32'h1234_5001);
    // R11 second way of same set
    lookup(32'h1234_5010, 2'd1, 1'b0, mk(32'h0077_7010, 1, 0, 0, 0, "R11 way1 hit"));
    cfg_read(1'b0, 1, 5, rd);
    check(rd == 32'h1234_5003, "R7 way1 marked", rd, 32'h1234_5003);
    cfg_read(1'b0, 0, 5, rd);
    check(rd == 32'h4000_5001, "R7 way0 cleared", rd, 32'h4000_5001);

    // R8 protection
    lookup(32'h4000_5000, 2'd1, 1'b0, mk(32'h4000_5000, 0, 0, 1, 0, "R8 user store"));
    cfg_read(1'b0, 1, 5, rd);
    check(rd == 32'h1234_5003, "R7 fault keeps bits", rd, 32'h1234_5003);
    lookup(32'h4000_5004, 2'd1, 1'b1, mk(32'h4000_5004, 0, 0, 1, 0, "R8 sup store"));
    lookup(32'h4000_5008, 2'd2, 1'b0, mk(32'h8012_3008, 1, 0, 0, 1, "R8 user fetch"));
    lookup(32'h1234_5FF0, 2'd1, 1'b1, mk(32'h0077_7FF0, 1, 0, 0, 0, "R8 sup store ok"));

    // R4 miss in empty set
    lookup(32'h5000_6000, 2'd0, 1'b0, mk(32'h5000_6000, 0, 1, 0, 0, "R4 miss"));

    // R6 entry in wrong set
    cfg_write(1'b0, 0, 3, 32'h00AB_5001);
    cfg_write(1'b1, 0, 3, 32'h0000_13C0);
    lookup(32'h00AB_5000, 2'd0, 1'b0, mk(32'h00AB_5000, 0, 1, 0, 0, "R6 wrong set"));

    // R5 clear only the valid bit
    cfg_write(1'b0, 0, 5, 32'h4000_5000);
    cfg_read(1'b0, 0, 5, rd);
    check(rd == 32'h4000_5000, "R5 vpn kept", rd, 32'h4000_5000);
    lookup(32'h4000_5ABC, 2'd0, 1'b0, mk(32'h4000_5ABC, 0, 1, 0, 0, "R5 invalid miss"));

    // R2 zero write invalidates
    cfg_write(1'b0, 1, 5, 32'h0);
    lookup(32'h1234_5000, 2'd0, 1'b0, mk(32'h1234_5000, 0, 1, 0, 0, "R2 zeroed miss"));
    cfg_write(1'b0, 1, 5, 32'h1234_5001);

    // R9 translation disabled
    @(negedge clk);
    ea_keep = fault_ea;
    xlate_en = 1'b0;
    lookup(32'h1234_5678, 2'd1, 1'b0, mk(32'h1234_5678, 0, 0, 0, 0, "R9 bypass"));
    #(CLK_PERIOD/4);
    check(fault_ea == ea_keep, "R9 fault_ea kept", fault_ea, ea_keep);

    // R10 back-pressure
    xlate_en = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    lookup(32'h1234_5020, 2'd0, 1'b1, mk(32'h0077_7020, 1, 0, 0, 0, "R10 stalled"));
    #(CLK_PERIOD/4);
    check(res_valid && !lk_ready, "R10 stall ready low",
          {30'd0, res_valid, lk_ready}, 32'h2);
    repeat (2) @(negedge clk);
    #(CLK_PERIOD/4);
    check(res_pa == 32'h0077_7020 && res_valid, "R10 held result", res_pa, 32'h0077_7020);
    check(!lk_ready, "R10 ready still low", {31'd0, lk_ready}, 32'h0);
    @(negedge clk);
    res_ready = 1'b1;
    lookup(32'h1234_5030, 2'd0, 1'b0, mk(32'h0077_7030, 1, 0, 0, 0, "R10 after release"));

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10 all results delivered", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule